// File: doc/BRIEF.md
# Timestamp Record Queue with Word-Serial Readout

This block keeps event timestamp records for one port in one direction until a processor collects them. A capture strobe stores a complete record in one cycle: a 16-bit tag whose low three bits give the message kind, a 48-bit seconds count, a 32-bit nanoseconds count, a 64-bit clock identity, a 16-bit port number and a 16-bit sequence id. Up to 90 records wait in first-in, first-out order.

The processor drains the oldest record through a single 16-bit data register. It takes exactly twelve reads per record. A status register shows a capture enable, the reader's word position inside the current record and a saturating count of records that were lost because the queue was full. A not-empty flag goes to a buffer status word that is assembled outside this block. In that word, transmit flags for ports 1 to 3 take bits 0 to 2 and receive flags take bits 3 to 5.

Top module: `tsq_top`

## Requirements
- R1: A record is read as twelve 16-bit words. The order is: the tag word, three seconds words, two nanoseconds words, four clock identity words, the port number and the sequence id. Multi-word fields come most significant word first. The tag is returned unchanged, including its low 3 bits (1 sync, 2 peer delay request, 3 peer delay response, 4 delay request).
- R2: Status bits 12:8 hold the read position. It is 0 at the start of a record and increases by one for each data read.
- R3: The twelfth read of a record returns the position to 0 and removes that record. The next read then returns the tag word of the following record.
- R4: The queue holds 90 records and returns them in the order they were captured.
- R5: Status bit 15 is the capture enable, and it is 0 after reset. While it is 0, a capture strobe stores nothing and does not change the discard count.
- R6: A capture strobe that arrives while enabled and full is dropped. It increments the discard count in status bits 7:4, which stops at 15.
- R7: A data read while the queue is empty returns 0 and leaves the read position unchanged.
- R8: A status write sets the enable from bit 15. If bit 15 is 1, the write also clears the discard count and the read position, and no record is removed. If bit 15 is 0, both are kept.
- R9: After reset, status reads 0x0000 and not_empty is 0. not_empty is 1 exactly while at least one record is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_valid | input | 1 | Capture strobe for one record |
| cap_tag | input | 16 | Message tag |
| cap_sec | input | 48 | Seconds |
| cap_nsec | input | 32 | Nanoseconds |
| cap_clkid | input | 64 | Clock identity |
| cap_port | input | 16 | Port number |
| cap_seq | input | 16 | Sequence id |
| rd_en | input | 1 | Data register read strobe |
| rd_data | output | 16 | Current data word (0 when empty) |
| stat_wr | input | 1 | Status register write strobe |
| stat_wdata | input | 16 | Status write data (bit 15 used) |
| stat_rdata | output | 16 | Status register: enable, position, discards |
| not_empty | output | 1 | At least one record is stored |

## Verification
All three read-side outputs are decoded combinationally from registered state. After a capture, read or status write, the new value is therefore visible from the clock edge that takes the strobe until the next one. The bench drives each strobe on a falling edge for one cycle. It samples rd_data, stat_rdata and not_empty on a later falling edge, which is half a cycle after the edge that updated them. A word is checked before its read strobe is applied, so each check sees the word the processor would get from that read.

// File: rtl/tsq_pkg.sv
package tsq_pkg;
  localparam int WORD_W    = 16;
  localparam int REC_WORDS = 12;
  localparam int REC_W     = WORD_W * REC_WORDS;
  localparam int POS_W     = 5;
  localparam int DISC_W    = 4;

  typedef logic [REC_W-1:0] rec_t;

  // Flatten a record, tag in the most significant word.
  function automatic rec_t pack_rec(input logic [15:0] tag, input logic [47:0] sec,
                                    input logic [31:0] nsec, input logic [63:0] clkid,
                                    input logic [15:0] port, input logic [15:0] seq);
    return {tag, sec, nsec, clkid, port, seq};
  endfunction

  // Word idx of a record, counted from the most significant end.
  function automatic logic [WORD_W-1:0] rec_word(input rec_t r, input logic [POS_W-1:0] idx);
    logic [WORD_W-1:0] w;
    w = '0;
    for (int i = 0; i < REC_WORDS; i++)
      if (int'(idx) == i) w = r[REC_W-1-WORD_W*i -: WORD_W];
    return w;
  endfunction

  function automatic logic [DISC_W-1:0] sat_inc(input logic [DISC_W-1:0] v);
    return (v == '1) ? v : v + 1'b1;
  endfunction
endpackage

// File: rtl/tsq_store.sv
module tsq_store #(
  parameter int DEPTH = 90,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  tsq_pkg::rec_t wr_rec,
  output tsq_pkg::rec_t head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  tsq_pkg::rec_t mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wr_rec;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= nxt(wr_ptr);
      if (pop)  rd_ptr <= nxt(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign head  = mem[rd_ptr];
  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
endmodule

// File: rtl/tsq_reader.sv
module tsq_reader (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rd_en,
  input  logic                     empty,
  input  logic                     clr,
  output logic [tsq_pkg::POS_W-1:0] pos,
  output logic                     pop
);
  localparam logic [tsq_pkg::POS_W-1:0] LAST = tsq_pkg::POS_W'(tsq_pkg::REC_WORDS - 1);

  logic adv, at_last;
  assign adv     = rd_en && !empty && !clr;
  assign at_last = (pos == LAST);
  assign pop     = adv && at_last;

  always_ff @(posedge clk) begin
    if (!rst_n)   pos <= '0;
    else if (clr) pos <= '0;
    else if (adv) pos <= at_last ? '0 : pos + 1'b1;
  end
endmodule

// File: rtl/tsq_ctrl.sv
module tsq_ctrl (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      stat_wr,
  input  logic [15:0]               stat_wdata,
  input  logic                      drop,
  output logic                      en,
  output logic [tsq_pkg::DISC_W-1:0] disc,
  output logic                      clr
);
  logic unused_wbits;
  assign unused_wbits = ^stat_wdata[14:0];
  assign clr = stat_wr && stat_wdata[15];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en   <= 1'b0;
      disc <= '0;
    end else begin
      if (stat_wr) en <= stat_wdata[15];
      if (clr)       disc <= '0;
      else if (drop) disc <= tsq_pkg::sat_inc(disc);
    end
  end
endmodule

// File: rtl/tsq_top.sv
module tsq_top #(
  parameter int DEPTH = 90
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cap_valid,
  input  logic [15:0] cap_tag,
  input  logic [47:0] cap_sec,
  input  logic [31:0] cap_nsec,
  input  logic [63:0] cap_clkid,
  input  logic [15:0] cap_port,
  input  logic [15:0] cap_seq,
  input  logic        rd_en,
  output logic [15:0] rd_data,
  input  logic        stat_wr,
  input  logic [15:0] stat_wdata,
  output logic [15:0] stat_rdata,
  output logic        not_empty
);
  localparam int CW = $clog2(DEPTH + 1);

  tsq_pkg::rec_t                 head;
  logic [CW-1:0]                 count;
  logic                          full, empty, en, clr, pop;
  logic                          push_ok, drop;
  logic [tsq_pkg::POS_W-1:0]     rd_pos;
  logic [tsq_pkg::DISC_W-1:0]    disc;

  assign push_ok = cap_valid && en && !full;
  assign drop    = cap_valid && en && full;

  tsq_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .push(push_ok), .pop(pop),
    .wr_rec(tsq_pkg::pack_rec(cap_tag, cap_sec, cap_nsec, cap_clkid, cap_port, cap_seq)),
    .head(head), .count(count), .full(full), .empty(empty)
  );

  tsq_reader u_reader (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .empty(empty), .clr(clr),
    .pos(rd_pos), .pop(pop)
  );

  tsq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
    .drop(drop), .en(en), .disc(disc), .clr(clr)
  );

  assign rd_data    = empty ? 16'h0000 : tsq_pkg::rec_word(head, rd_pos);
  assign stat_rdata = {en, 2'b00, rd_pos, disc, 4'h0};
  assign not_empty  = !empty;
endmodule

// File: rtl/tsq_chk.sv
module tsq_chk #(
  parameter int DEPTH = 90,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      en,
  input logic                      push_ok,
  input logic                      pop,
  input logic                      clr,
  input logic                      rd_en,
  input logic                      empty,
  input logic [CW-1:0]             count,
  input logic [tsq_pkg::POS_W-1:0]  rd_pos,
  input logic [tsq_pkg::DISC_W-1:0] disc
);
  // R2
  pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pos <= tsq_pkg::POS_W'(tsq_pkg::REC_WORDS - 1));
  // R3
  pop_at_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> rd_pos == tsq_pkg::POS_W'(tsq_pkg::REC_WORDS - 1));
  // R4
  occupancy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  // R5
  disabled_nopush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !push_ok);
  // R6
  disc_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disc == '1 && !clr) |=> disc == '1);
  // R7
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && empty && !clr) |=> $stable(rd_pos));
  // R8
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (rd_pos == '0 && disc == '0));
endmodule

bind tsq_top tsq_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .push_ok(push_ok), .pop(pop), .clr(clr),
  .rd_en(rd_en), .empty(empty), .count(count), .rd_pos(rd_pos), .disc(disc)
);

// File: tb/tb_tsq_top.sv
module tb_tsq_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, cap_valid, rd_en, stat_wr, not_empty;
  logic [15:0] cap_tag, cap_port, cap_seq, rd_data, stat_wdata, stat_rdata;
  logic [47:0] cap_sec;
  logic [31:0] cap_nsec;
  logic [63:0] cap_clkid;

  int n_tests = 0;
  int n_fail  = 0;

  tsq_top dut (
    .clk(clk), .rst_n(rst_n), .cap_valid(cap_valid), .cap_tag(cap_tag),
    .cap_sec(cap_sec), .cap_nsec(cap_nsec), .cap_clkid(cap_clkid),
    .cap_port(cap_port), .cap_seq(cap_seq), .rd_en(rd_en), .rd_data(rd_data),
    .stat_wr(stat_wr), .stat_wdata(stat_wdata), .stat_rdata(stat_rdata),
    .not_empty(not_empty)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected word i of record k, written per word.
  function automatic logic [15:0] wexp(input int k, input int i);
    case (i)
      0:  return 16'((k << 3) | (k % 4 + 1));
      1:  return 16'(16'hA000 + k);
      2:  return 16'(k * 7);
      3:  return 16'(k ^ 16'h5A5A);
      4:  return 16'(k * 3 + 1);
      5:  return 16'(16'hFFFF - k);
      6:  return 16'(16'hC000 + k);
      7:  return 16'(k * 5);
      8:  return 16'(16'h00FF ^ k);
      9:  return 16'(k + 2);
      10: return 16'(16'h0100 + k);
      default: return 16'(16'h8000 - k);
    endcase
  endfunction

  task automatic cap(input int k);
    cap_valid = 1'b1;
    cap_tag   = wexp(k, 0);
    cap_sec   = {wexp(k, 1), wexp(k, 2), wexp(k, 3)};
    cap_nsec  = {wexp(k, 4), wexp(k, 5)};
    cap_clkid = {wexp(k, 6), wexp(k, 7), wexp(k, 8), wexp(k, 9)};
    cap_port  = wexp(k, 10);
    cap_seq   = wexp(k, 11);
    @(negedge clk);
    cap_valid = 1'b0;
  endtask

  task automatic pulse_rd();
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wr_stat(input logic [15:0] v);
    stat_wr = 1'b1;
    stat_wdata = v;
    @(negedge clk);
    stat_wr = 1'b0;
  endtask

  function automatic logic [15:0] pos_of(input logic [15:0] s);
    return {11'b0, s[12:8]};
  endfunction

  task automatic read_rec(input int k);
    for (int i = 0; i < 12; i++) begin
      chk("R1 word", rd_data, wexp(k, i));
      chk("R2 position", pos_of(stat_rdata), 16'(i));
      pulse_rd();
    end
    chk("R3 position wraps", pos_of(stat_rdata), 16'h0000);
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cap_valid = 1'b0; rd_en = 1'b0; stat_wr = 1'b0;
    stat_wdata = '0; cap_tag = '0; cap_sec = '0; cap_nsec = '0;
    cap_clkid = '0; cap_port = '0; cap_seq = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 reset state
    chk("R9 status after reset", stat_rdata, 16'h0000);
    chk("R9 not_empty after reset", {15'b0, not_empty}, 16'h0000);
    chk("R7 data when empty", rd_data, 16'h0000);

    // R5 capture while disabled
    cap(7);
    chk("R5 no record while disabled", {15'b0, not_empty}, 16'h0000);
    chk("R5 no discard while disabled", stat_rdata, 16'h0000);

    wr_stat(16'h8000);
    chk("R8 enable set", stat_rdata, 16'h8000);

    // R1/R2/R3 three records, each message kind pattern
    for (int k = 1; k <= 3; k++) cap(k);
    chk("R9 not_empty with records", {15'b0, not_empty}, 16'h0001);
    for (int k = 1; k <= 3; k++) begin
      read_rec(k);
      chk("R3 next tag", rd_data, (k < 3) ? wexp(k + 1, 0) : 16'h0000);
    end
    chk("R9 not_empty drained", {15'b0, not_empty}, 16'h0000);

    // R7 read on empty
    pulse_rd();
    chk("R7 data stays zero", rd_data, 16'h0000);
    chk("R7 position unchanged", stat_rdata, 16'h8000);

    // R4/R6 fill, overflow, saturate
    for (int k = 0; k < 90; k++) cap(100 + k);
    chk("R6 no discard at exactly full", stat_rdata, 16'h8000);
    for (int k = 0; k < 3; k++) cap(500 + k);
    chk("R6 three discards", stat_rdata, 16'h8030);
    for (int k = 0; k < 15; k++) cap(600 + k);
    chk("R6 discard saturates", stat_rdata, 16'h80F0);
    for (int k = 0; k < 90; k++) read_rec(100 + k);
    chk("R4 empty after 90", {15'b0, not_empty}, 16'h0000);

    // R8 partial read then writes
    cap(200);
    cap(201);
    for (int i = 0; i < 5; i++) pulse_rd();
    chk("R2 mid-record position", stat_rdata, 16'h85F0);
    wr_stat(16'h0000);
    chk("R8 disable keeps position and count", stat_rdata, 16'h05F0);
    cap(300);
    wr_stat(16'h8000);
    chk("R8 clear position and count", stat_rdata, 16'h8000);
    chk("R8 record not removed", rd_data, wexp(200, 0));
    read_rec(200);
    read_rec(201);
    chk("R5 disabled capture absent", {15'b0, not_empty}, 16'h0000);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule